// File: doc/BRIEF.md
# Prefetch Candidate Queue with Demand-Line Squash

This block holds hardware prefetch candidates that are waiting for a free slot on the memory port. Each candidate is a physical address and a secure-domain flag. The prefetch engine writes candidates through a push port. The memory side takes them through a valid/ready pop port, oldest first.

The cache also reports every demand access to the queue, with its address and secure flag. When squashing is enabled, every queued candidate in the demanded cache line and in the same security domain is dropped in that cycle, because the demand fetch already brings that line in. Addresses are reduced to their line address before they are compared. A candidate at any byte offset inside the demanded line is therefore removed, not only one that sits on the line boundary. The survivors are compacted towards the head, so the order in which they leave the queue does not change.

Top module: `pfq_squash_queue`

## Requirements
- R1: Candidates leave through the pop port in the order they were accepted. A push that is not dropped or squashed is always accepted.
- R2: While `pop_valid` is high and `pop_ready` is low, and no squash is requested, `pop_addr` and `pop_secure` hold their values.
- R3: With `squash_en` and `dem_valid` high, a queued entry is removed when its address with the low log2(BLK_BYTES) bits cleared equals the demand address with the same bits cleared. An entry at byte offset 0x28 of the demanded 64-byte line is removed.
- R4: An entry whose secure flag differs from `dem_secure` is never removed, even when it is in the demanded line.
- R5: An entry in a different line from the demand is never removed.
- R6: When `squash_en` is low, a demand access removes nothing.
- R7: A single demand removes every matching entry, wherever it sits in the queue. The remaining entries keep their relative order.
- R8: A push while all DEPTH slots are occupied is discarded and leaves the contents unchanged. `drop_strobe` is high in exactly the cycles in which `push_valid` is high and the queue is full.
- R9: A candidate pushed in the same cycle as a matching demand with squashing enabled is not stored.
- R10: After reset the queue is empty: `pop_valid` is low.
- R11: A pop handshake (`pop_valid` and `pop_ready` both high at a clock edge) removes the head. The next oldest entry is presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| squash_en | input | 1 | Configuration bit that enables removal on demand |
| push_valid | input | 1 | A new candidate is offered this cycle |
| push_addr | input | ADDR_W | Physical address of the candidate |
| push_secure | input | 1 | Secure flag of the candidate |
| dem_valid | input | 1 | A demand access is observed this cycle |
| dem_addr | input | ADDR_W | Address of the demand access |
| dem_secure | input | 1 | Secure flag of the demand access |
| pop_valid | output | 1 | The head entry is available |
| pop_ready | input | 1 | The memory port takes the head this cycle |
| pop_addr | output | ADDR_W | Address of the head entry |
| pop_secure | output | 1 | Secure flag of the head entry |
| drop_strobe | output | 1 | One-cycle pulse per candidate discarded because the queue is full |

## Verification
Any corruption of the valid vector or of the compaction shows up at the pop port no later than the next pop. It appears as a missing, duplicated or reordered address, or as `pop_valid` disagreeing with the number of accepted candidates. A wrong line mask, for example one that compares full addresses, leaves offset-0x28 entries behind, and those appear on the first drain after the demand. A wrong occupancy notion shows up in the same cycle, as `drop_strobe` being high with free slots or low with none.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   localparam int unsigned PFQ_ADDR_W_DEF = 32;
   localparam int unsigned PFQ_DEPTH_DEF  = 8;
   localparam int unsigned PFQ_BLK_DEF    = 64;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pfq_line_match.sv
module pfq_line_match #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFS_W  = 6
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_sec,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_sec,
   output logic              hit
);
   logic [ADDR_W-OFS_W-1:0] a_line, b_line;

   assign a_line = a_addr[ADDR_W-1:OFS_W];
   assign b_line = b_addr[ADDR_W-1:OFS_W];
   assign hit    = en && (a_line == b_line) && (a_sec == b_sec);
endmodule

// File: rtl/pfq_compact.sv
module pfq_compact #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input  logic [DEPTH-1:0]  keep,
   input  logic [ADDR_W-1:0] addr_in [DEPTH],
   input  logic [DEPTH-1:0]  sec_in,
   input  logic              push_en,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              push_sec,
   output logic [DEPTH-1:0]  vld_out,
   output logic [ADDR_W-1:0] addr_out [DEPTH],
   output logic [DEPTH-1:0]  sec_out
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   logic [CNT_W-1:0] slot;

   always_comb begin
      vld_out = '0;
      sec_out = '0;
      for (int j = 0; j < DEPTH; j++) addr_out[j] = '0;
      slot = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (keep[i]) begin
            addr_out[slot[IDX_W-1:0]] = addr_in[i];
            sec_out[slot[IDX_W-1:0]]  = sec_in[i];
            vld_out[slot[IDX_W-1:0]]  = 1'b1;
            slot = slot + CNT_W'(1);
         end
      end
      if (push_en && (slot < CNT_W'(DEPTH))) begin
         addr_out[slot[IDX_W-1:0]] = push_addr;
         sec_out[slot[IDX_W-1:0]]  = push_sec;
         vld_out[slot[IDX_W-1:0]]  = 1'b1;
      end
   end
endmodule

// File: rtl/pfq_squash_queue.sv
module pfq_squash_queue
   import pfq_pkg::*;
#(
   parameter int unsigned ADDR_W    = PFQ_ADDR_W_DEF,
   parameter int unsigned DEPTH     = PFQ_DEPTH_DEF,
   parameter int unsigned BLK_BYTES = PFQ_BLK_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              squash_en,
   input  logic              push_valid,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              push_secure,
   input  logic              dem_valid,
   input  logic [ADDR_W-1:0] dem_addr,
   input  logic              dem_secure,
   output logic              pop_valid,
   input  logic              pop_ready,
   output logic [ADDR_W-1:0] pop_addr,
   output logic              pop_secure,
   output logic              drop_strobe
);
   localparam int unsigned OFS_W = $clog2(BLK_BYTES);

   if (!is_pow2(BLK_BYTES)) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (OFS_W >= ADDR_W) begin : g_bad_width
      $error("ADDR_W must exceed log2(BLK_BYTES)");
   end

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DEPTH-1:0]  vld_q, sec_q;
   logic [ADDR_W-1:0] addr_n [DEPTH];
   logic [DEPTH-1:0]  vld_n, sec_n;
   logic [DEPTH-1:0]  kill, keep;
   logic              sq_act, push_kill, full, pop_fire, push_ok;

   assign sq_act   = squash_en && dem_valid;
   assign full     = vld_q[DEPTH-1];
   assign pop_fire = vld_q[0] && pop_ready;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      pfq_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_m (
         .en    (sq_act),
         .a_addr(addr_q[i]),
         .a_sec (sec_q[i]),
         .b_addr(dem_addr),
         .b_sec (dem_secure),
         .hit   (kill[i])
      );
   end

   pfq_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_push_m (
      .en    (sq_act),
      .a_addr(push_addr),
      .a_sec (push_secure),
      .b_addr(dem_addr),
      .b_sec (dem_secure),
      .hit   (push_kill)
   );

   assign keep    = vld_q & ~kill & ~{{(DEPTH-1){1'b0}}, pop_fire};
   assign push_ok = push_valid && !full && !push_kill;

   pfq_compact #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cmp (
      .keep     (keep),
      .addr_in  (addr_q),
      .sec_in   (sec_q),
      .push_en  (push_ok),
      .push_addr(push_addr),
      .push_sec (push_secure),
      .vld_out  (vld_n),
      .addr_out (addr_n),
      .sec_out  (sec_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         sec_q <= '0;
         for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
      end else begin
         vld_q <= vld_n;
         sec_q <= sec_n;
         for (int i = 0; i < DEPTH; i++) addr_q[i] <= addr_n[i];
      end
   end

   assign pop_valid   = vld_q[0];
   assign pop_addr    = addr_q[0];
   assign pop_secure  = sec_q[0];
   assign drop_strobe = push_valid && full;
endmodule

// File: rtl/pfq_squash_queue_chk.sv
module pfq_squash_queue_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_BYTES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              squash_en,
   input logic              push_valid,
   input logic [ADDR_W-1:0] push_addr,
   input logic              push_secure,
   input logic              dem_valid,
   input logic [ADDR_W-1:0] dem_addr,
   input logic              dem_secure,
   input logic              pop_valid,
   input logic              pop_ready,
   input logic [ADDR_W-1:0] pop_addr,
   input logic              pop_secure,
   input logic              drop_strobe
);
   localparam int unsigned OFS_W = $clog2(BLK_BYTES);

   // R10: first cycle out of reset shows an empty queue
   a_r10_empty_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !pop_valid);

   // R2: a stalled head does not move unless a squash is requested
   a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid && !pop_ready && !(squash_en && dem_valid)
      |=> pop_valid && $stable(pop_addr) && $stable(pop_secure));

   // R3: a squashed head is not replaced by an entry of the same line and domain
   a_r3_head_squashed: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid && !pop_ready && squash_en && dem_valid &&
      (pop_secure == dem_secure) &&
      (pop_addr[ADDR_W-1:OFS_W] == dem_addr[ADDR_W-1:OFS_W])
      |=> !pop_valid || (pop_secure != $past(dem_secure)) ||
          (pop_addr[ADDR_W-1:OFS_W] != $past(dem_addr[ADDR_W-1:OFS_W])));

   // R8: a drop needs an offered candidate and an occupied queue
   a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      drop_strobe |-> push_valid && pop_valid);

   // R9: into an empty queue, a candidate killed by a same-cycle demand stays out
   a_r9_push_squashed: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid && push_valid && squash_en && dem_valid &&
      (push_secure == dem_secure) &&
      (push_addr[ADDR_W-1:OFS_W] == dem_addr[ADDR_W-1:OFS_W])
      |=> !pop_valid);
endmodule

bind pfq_squash_queue pfq_squash_queue_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .squash_en(squash_en),
   .push_valid(push_valid), .push_addr(push_addr), .push_secure(push_secure),
   .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_secure(dem_secure),
   .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_addr(pop_addr),
   .pop_secure(pop_secure), .drop_strobe(drop_strobe)
);

// File: tb/sim_pfq_squash_queue.sv
module sim_pfq_squash_queue;
   localparam int unsigned AW    = 32;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned BLK   = 64;
   localparam int unsigned OFS   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          squash_en = 1'b0;
   logic          push_valid = 1'b0;
   logic [AW-1:0] push_addr = '0;
   logic          push_secure = 1'b0;
   logic          dem_valid = 1'b0;
   logic [AW-1:0] dem_addr = '0;
   logic          dem_secure = 1'b0;
   logic          pop_ready = 1'b0;
   logic          pop_valid, pop_secure, drop_strobe;
   logic [AW-1:0] pop_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [AW:0] mq [$];

   always #5 clk = ~clk;

   pfq_squash_queue #(.ADDR_W(AW), .DEPTH(DEPTH), .BLK_BYTES(BLK)) u0 (
      .clk(clk), .rst_n(rst_n), .squash_en(squash_en),
      .push_valid(push_valid), .push_addr(push_addr), .push_secure(push_secure),
      .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_secure(dem_secure),
      .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_addr(pop_addr),
      .pop_secure(pop_secure), .drop_strobe(drop_strobe)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit same_line(input logic [AW:0] e, input logic [AW-1:0] a, input logic s);
      return (e[AW] == s) && (e[AW-1:OFS] == a[AW-1:OFS]);
   endfunction

   // monitor / scoreboard: compares outputs, then advances the model by this cycle
   always @(negedge clk) begin
      if (!rst_n) begin
         mq.delete();
      end else begin
         automatic bit full = (mq.size() == DEPTH);
         automatic logic [AW:0] keep_q [$];
         chk(pop_valid == (mq.size() != 0), "R1 pop_valid vs accepted count",
             64'(pop_valid), 64'(mq.size() != 0));
         if (pop_valid && mq.size() != 0)
            chk({pop_secure, pop_addr} == mq[0], "R1 head order",
                64'({pop_secure, pop_addr}), 64'(mq[0]));
         chk(drop_strobe == (push_valid && full), "R8 drop strobe",
             64'(drop_strobe), 64'(push_valid && full));
         if (pop_ready && mq.size() != 0) void'(mq.pop_front());
         if (squash_en && dem_valid) begin
            foreach (mq[k]) if (!same_line(mq[k], dem_addr, dem_secure)) keep_q.push_back(mq[k]);
            mq = keep_q;
         end
         if (push_valid && !full &&
             !(squash_en && dem_valid && same_line({push_secure, push_addr}, dem_addr, dem_secure)))
            mq.push_back({push_secure, push_addr});
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push1(input logic [AW-1:0] a, input logic s);
      push_valid = 1'b1; push_addr = a; push_secure = s;
      cyc();
      push_valid = 1'b0;
   endtask

   task automatic drain(input logic [AW:0] exp [$], input string tag);
      logic [AW:0] got [$];
      bit more = 1;
      push_valid = 1'b0; dem_valid = 1'b0; pop_ready = 1'b1;
      while (more) begin
         @(negedge clk);
         if (pop_valid) got.push_back({pop_secure, pop_addr});
         else more = 0;
      end
      @(posedge clk); #1;
      pop_ready = 1'b0;
      chk(got.size() == exp.size(), {tag, " drained count"}, 64'(got.size()), 64'(exp.size()));
      foreach (exp[k])
         if (k < got.size()) chk(got[k] == exp[k], {tag, " drained entry"}, 64'(got[k]), 64'(exp[k]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW:0] exp [$];
      repeat (3) cyc();
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pop_valid, "R10 empty after reset", 64'(pop_valid), 64'd0);
      chk(!drop_strobe, "R10 no drop after reset", 64'(drop_strobe), 64'd0);
      cyc();

      // R1 / R11: plain FIFO order
      push1(32'h0000_0100, 1'b0);
      push1(32'h0000_0240, 1'b1);
      push1(32'h0000_0380, 1'b0);
      drain('{33'h0_0000_0100, 33'h1_0000_0240, 33'h0_0000_0380}, "R1 R11 order");

      // R2: head held while stalled
      push1(32'h0000_0A00, 1'b0);
      push1(32'h0000_0B00, 1'b0);
      repeat (4) cyc();
      @(negedge clk);
      chk(pop_addr == 32'h0000_0A00, "R2 stalled head", 64'(pop_addr), 64'h0A00);
      cyc();
      drain('{33'h0_0000_0A00, 33'h0_0000_0B00}, "R2 after stall");

      // R3 R4 R5 R7: squash within line 0x1000, secure 0
      squash_en = 1'b1;
      push1(32'h0000_1028, 1'b0);
      push1(32'h0000_1028, 1'b1);
      push1(32'h0000_2000, 1'b0);
      push1(32'h0000_1000, 1'b0);
      push1(32'h0000_103C, 1'b0);
      push1(32'h0000_2010, 1'b1);
      dem_valid = 1'b1; dem_addr = 32'h0000_1010; dem_secure = 1'b0;
      cyc();
      dem_valid = 1'b0;
      drain('{33'h1_0000_1028, 33'h0_0000_2000, 33'h1_0000_2010}, "R3 R4 R5 R7 squash");

      // R6: squash disabled
      squash_en = 1'b0;
      push1(32'h0000_3028, 1'b0);
      dem_valid = 1'b1; dem_addr = 32'h0000_3000; dem_secure = 1'b0;
      cyc();
      dem_valid = 1'b0;
      drain('{33'h0_0000_3028}, "R6 disabled");

      // R8: overflow
      exp.delete();
      for (int i = 0; i < DEPTH; i++) begin
         push1(AW'(32'h0001_0000 + i * 32'h40), 1'b0);
         exp.push_back({1'b0, AW'(32'h0001_0000 + i * 32'h40)});
      end
      push_valid = 1'b1; push_addr = 32'h0000_F000; push_secure = 1'b0;
      @(negedge clk);
      chk(drop_strobe, "R8 strobe when full", 64'(drop_strobe), 64'd1);
      cyc();
      push_valid = 1'b0;
      @(negedge clk);
      chk(!drop_strobe, "R8 strobe clears", 64'(drop_strobe), 64'd0);
      cyc();
      drain(exp, "R8 contents kept");

      // R9: same-cycle push and demand on one line
      squash_en = 1'b1;
      push1(32'h0000_5000, 1'b0);
      push_valid = 1'b1; push_addr = 32'h0000_4030; push_secure = 1'b0;
      dem_valid = 1'b1; dem_addr = 32'h0000_4000; dem_secure = 1'b0;
      cyc();
      push_valid = 1'b0; dem_valid = 1'b0;
      drain('{33'h0_0000_5000}, "R9 push squashed");

      // mixed traffic, checked cycle by cycle by the monitor
      for (int n = 0; n < 3000; n++) begin
         push_valid  = ($urandom % 3) != 0;
         push_addr   = {24'd0, 2'b00, 3'($urandom), 3'($urandom)} << 3;
         push_secure = 1'($urandom);
         dem_valid   = ($urandom % 4) == 0;
         dem_addr    = {24'd0, 2'b00, 3'($urandom), 3'($urandom)} << 3;
         dem_secure  = 1'($urandom);
         squash_en   = ($urandom % 5) != 0;
         pop_ready   = ($urandom % 3) == 0;
         cyc();
      end
      push_valid = 1'b0; dem_valid = 1'b0; pop_ready = 1'b1;
      repeat (DEPTH + 2) cyc();
      @(negedge clk);
      chk(!pop_valid, "R11 empty after drain", 64'(pop_valid), 64'd0);
      cyc();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule